// File: doc/BRIEF.md
# Escaped Run-Length Byte Decoder

This block expands a compressed byte stream in which runs are flagged inside the data. Any two equal consecutive bytes start a run. The byte that follows such a pair is a count, and the decoder emits that many further copies of the repeated byte. Bytes that do not form a pair pass through without change. Bytes enter on a valid/ready stream and decoded bytes leave on a second valid/ready stream. Each side moves at most one byte per clock, and a stalled output holds the run expansion where it is.

A plain byte goes from input to output in the same cycle, with no register in the path. The second byte of a pair is not sent when it is accepted. It is sent in the cycle that consumes the count byte, so the output sequence is unchanged but the count and the pair byte use the same handshake. A last flag on the input marks the end of a packet. It is moved to whichever decoded byte ends that packet, and it clears the pairing history.

Top module: `rle_decoder`

## Requirements
- R1: When no run or count is pending and an input byte does not match the stored previous byte, out_data equals in_data in the same cycle, out_valid follows in_valid and in_ready follows out_ready.
- R2: An input byte without last that equals a valid stored previous byte is accepted with in_ready high and out_valid low, and the decoder then waits for a count byte.
- R3: The count byte is never output. In the cycle it is offered, the output carries the pair byte, and the count is consumed only when that output handshake completes.
- R4: A count value N from 1 to 255 makes the decoder emit N more copies of the pair byte after the pair byte itself, so the run totals N+2 bytes.
- R5: A count of 0 adds no copies, and the next input byte is handled as a pass-through byte.
- R6: After a count byte is consumed, the stored previous byte is invalid, so the next input byte cannot pair with the finished run.
- R7: While copies are being emitted, in_ready is low, out_valid is high, and out_data and the number of remaining copies stay unchanged on cycles where out_ready is low.
- R8: A count of 255 (the largest 8-bit count) gives exactly 255 extra copies.
- R9: out_last is set only on the last decoded byte of a packet. That byte is a pass-through byte with last, a pair byte with last (no count follows), the pair byte when its count is 0 with last, or the final copy of a run whose count byte carried last.
- R10: Synchronous active-high reset clears the stored previous byte, the count wait and the run counter. After reset, out_valid is low while in_valid is low, and any byte passes straight through.
- R11: A byte accepted with last leaves the stored previous byte invalid, so the first byte of the next packet does not pair with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder accepts the input byte |
| in_data | input | 8 | Encoded input byte |
| in_last | input | 1 | Input byte ends the packet |
| out_valid | output | 1 | Decoded byte valid |
| out_ready | input | 1 | Downstream accepts the decoded byte |
| out_data | output | 8 | Decoded byte |
| out_last | output | 1 | Decoded byte ends the packet |

## Verification
Two functions share one cycle. Consuming the count byte and emitting the pair byte both depend on the same output handshake, so the count must not be taken while out_ready is low. The same cycle also decides whether out_last belongs to the pair byte (count of 0) or moves on to the final run copy. The bench sends the count byte while a pseudo-random pattern drops out_ready. It checks that every expected byte and last flag arrives exactly once and in order, and it steps through the count cycle on its own to confirm that the pair byte is on the output while the count byte is on the input.

// File: rtl/rle_dec_pkg.sv
package rle_dec_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        PH_PASS  = 2'd0,
        PH_COUNT = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic  vld;
        byte_t data;
        logic  last;
    } beat_t;

    function automatic logic pair_hit(input logic held_vld, input byte_t held, input byte_t cur);
        return held_vld && (held == cur);
    endfunction

endpackage

// File: rtl/rle_prev_hold.sv
module rle_prev_hold #(
    parameter int W = rle_dec_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         load_vld,
    input  logic         clr,
    output logic [W-1:0] held,
    output logic         held_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            held_vld <= 1'b0;
        end else if (clr) begin
            held_vld <= 1'b0;
        end else if (load) begin
            held     <= load_val;
            held_vld <= load_vld;
        end
    end

    AST_CLR_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !held_vld); // R6

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr) |=> ($stable(held) && $stable(held_vld))); // R7

endmodule

// File: rtl/rle_run_ctr.sv
module rle_run_ctr #(
    parameter int W = rle_dec_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         at_one
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - ONE;
    end

    assign at_one = (cnt == ONE);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0)); // R4

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (cnt == $past(cnt) - ONE)); // R4

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!dec && !load) |=> $stable(cnt)); // R7

endmodule

// File: rtl/rle_decoder.sv
module rle_decoder
    import rle_dec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  byte_t in_data,
    input  logic  in_last,
    output logic  out_valid,
    input  logic  out_ready,
    output byte_t out_data,
    output logic  out_last
);

    phase_e ph;
    byte_t  held;
    logic   held_vld;
    cnt_t   run_cnt;
    logic   run_at_one;
    logic   run_last;

    logic   in_fire;
    logic   out_fire;
    logic   hit;
    logic   pair_wait;
    beat_t  ob;

    logic   prev_load;
    logic   prev_clr;
    logic   ctr_load;
    logic   ctr_dec;

    assign hit       = pair_hit(held_vld, held, in_data);
    assign pair_wait = hit && !in_last;

    always_comb begin
        ob       = '0;
        in_ready = 1'b0;
        case (ph)
            PH_PASS: begin
                if (pair_wait) begin
                    in_ready = 1'b1;
                end else begin
                    ob.vld   = in_valid;
                    ob.data  = in_data;
                    ob.last  = in_last;
                    in_ready = out_ready;
                end
            end
            PH_COUNT: begin
                ob.vld   = in_valid;
                ob.data  = held;
                ob.last  = in_last && (in_data == '0);
                in_ready = out_ready;
            end
            PH_RUN: begin
                ob.vld   = 1'b1;
                ob.data  = held;
                ob.last  = run_last && run_at_one;
            end
            default: begin
                ob = '0;
            end
        endcase
    end

    assign out_valid = ob.vld;
    assign out_data  = ob.data;
    assign out_last  = ob.last;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    assign prev_load = (ph == PH_PASS) && in_fire && !pair_wait;
    assign prev_clr  = (ph == PH_COUNT) && in_fire;
    assign ctr_load  = (ph == PH_COUNT) && in_fire && (in_data != '0);
    assign ctr_dec   = (ph == PH_RUN) && out_fire;

    rle_prev_hold #(.W(BYTE_W)) u_prev (
        .clk      (clk),
        .rst      (rst),
        .load     (prev_load),
        .load_val (in_data),
        .load_vld (!in_last),
        .clr      (prev_clr),
        .held     (held),
        .held_vld (held_vld)
    );

    rle_run_ctr #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (in_data),
        .dec      (ctr_dec),
        .cnt      (run_cnt),
        .at_one   (run_at_one)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_PASS;
            run_last <= 1'b0;
        end else begin
            case (ph)
                PH_PASS: begin
                    if (in_fire && pair_wait) ph <= PH_COUNT;
                end
                PH_COUNT: begin
                    if (in_fire) begin
                        run_last <= in_last;
                        ph       <= (in_data == '0) ? PH_PASS : PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (out_fire && run_at_one) ph <= PH_PASS;
                end
                default: ph <= PH_PASS;
            endcase
        end
    end

    AST_RUN_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RUN) |-> (!in_ready && out_valid)); // R7

    AST_RUN_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RUN && !out_ready) |=> (ph == PH_RUN && $stable(out_data))); // R7

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_COUNT && in_fire && in_data != '0) |=> (ph == PH_RUN && run_cnt == $past(in_data))); // R4

    AST_ZERO_COUNT_SKIPS: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_COUNT && in_fire && in_data == '0) |=> (ph == PH_PASS)); // R5

    AST_RUN_EXIT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RUN && out_fire && run_at_one) |=> (ph == PH_PASS && !held_vld)); // R6

    AST_LAST_CLEARS_PREV: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_PASS && in_fire && in_last) |=> !held_vld); // R11

    AST_PAIR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_PASS && in_valid && pair_wait) |-> (!out_valid && in_ready)); // R2

endmodule

// File: tb/tb_rle_decoder.sv
module tb_rle_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_last;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [7:0] in_b[$];
    logic       in_l[$];
    logic [7:0] exp_b[$];
    logic       exp_l[$];

    always #5ns clk = ~clk;

    rle_decoder dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // {last, byte}; each packet ends on an entry with last set
    localparam int NV = 33;
    localparam logic [8:0] VEC [NV] = '{
        9'h001, 9'h002, 9'h103,                                 // c0 R1
        9'h007, 9'h007, 9'h003, 9'h109,                         // c1 R2 R3 R4
        9'h00A, 9'h00A, 9'h000, 9'h10B,                         // c2 R5
        9'h00C, 9'h00C, 9'h002, 9'h00C, 9'h00C, 9'h000, 9'h10D, // c3 R6
        9'h021, 9'h121,                                         // c4 R9
        9'h030, 9'h030, 9'h102,                                 // c5 R9
        9'h040, 9'h040, 9'h100,                                 // c6 R9
        9'h166,                                                 // c7 R11
        9'h066, 9'h101,                                         // c8 R11
        9'h050, 9'h050, 9'h001, 9'h150                          // c9 R6 R9
    };

    function automatic string case_req(input int c);
        case (c)
            0: return "R1";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4, 5, 6, 9: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected stream built from the requirements
    function automatic void model();
        logic       pv = 1'b0;
        logic       wait_cnt = 1'b0;
        logic [7:0] pb = '0;
        exp_b.delete();
        exp_l.delete();
        foreach (in_b[i]) begin
            if (wait_cnt) begin
                exp_b.push_back(pb);
                exp_l.push_back(in_l[i] && in_b[i] == 8'h00);
                for (int k = 1; k <= int'(in_b[i]); k++) begin
                    exp_b.push_back(pb);
                    exp_l.push_back(in_l[i] && k == int'(in_b[i]));
                end
                wait_cnt = 1'b0;
                pv = 1'b0;
            end else if (pv && in_b[i] == pb && !in_l[i]) begin
                wait_cnt = 1'b1;
            end else begin
                exp_b.push_back(in_b[i]);
                exp_l.push_back(in_l[i]);
                pb = in_b[i];
                pv = !in_l[i];
            end
        end
    endfunction

    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    task automatic run_stream(input string req, input bit stall);
        int ip = 0;
        int cyc = 0;
        logic [7:0] gb[$];
        logic       gl[$];
        model();
        while ((ip < in_b.size() || gb.size() < exp_b.size()) && cyc < 4000) begin
            in_valid = (ip < in_b.size());
            in_data  = (ip < in_b.size()) ? in_b[ip] : 8'h00;
            in_last  = (ip < in_b.size()) ? in_l[ip] : 1'b0;
            lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
            @(negedge clk);
            if (out_valid && out_ready) begin
                gb.push_back(out_data);
                gl.push_back(out_last);
            end
            if (in_valid && in_ready) ip++;
            tick();
            cyc++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(gb.size() == exp_b.size(), req, "output length", gb.size(), exp_b.size());
        foreach (exp_b[i]) begin
            if (i < gb.size()) begin
                chk(gb[i] == exp_b[i], req, "output byte", gb[i], exp_b[i]);
                chk(gl[i] == exp_l[i], req, "output last", gl[i], exp_l[i]);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #1ms;
        checks++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        do_reset();

        // R10: reset state
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
        tick();

        // R1 R2 R3 R4 R7: one run traced cycle by cycle
        in_valid = 1'b1; in_data = 8'h44; in_last = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1", "in_ready follows out_ready low", in_ready, 0);
        chk(out_valid && out_data == 8'h44, "R1", "pass byte same cycle", out_data, 8'h44);
        out_ready = 1'b1;
        #1ns;
        chk(in_ready == 1'b1, "R1", "in_ready follows out_ready high", in_ready, 1);
        tick();
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", "pair byte held back", out_valid, 0);
        chk(in_ready == 1'b1, "R2", "pair byte accepted", in_ready, 1);
        tick();
        in_data = 8'h03; out_ready = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R3", "count waits for output handshake", in_ready, 0);
        tick();
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid && out_data == 8'h44, "R3", "pair byte in place of count", out_data, 8'h44);
        chk(in_ready == 1'b1, "R3", "count accepted", in_ready, 1);
        tick();
        in_data = 8'h99; out_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R7", "input blocked in stalled run", in_ready, 0);
            chk(out_valid && out_data == 8'h44, "R7", "run byte held in stall", out_data, 8'h44);
            tick();
        end
        out_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid && out_data == 8'h44, "R4", "run copy", out_data, 8'h44);
            chk(in_ready == 1'b0, "R7", "input blocked in run", in_ready, 0);
            tick();
        end
        @(negedge clk);
        chk(in_ready && out_valid && out_data == 8'h99, "R4", "pass after three copies", out_data, 8'h99);
        do_reset();

        // R10: reset in the middle of a run clears pairing and counter
        out_ready = 1'b1;
        in_valid = 1'b1; in_data = 8'h88; in_last = 1'b0;
        tick();
        tick();
        in_data = 8'h05;
        tick();
        tick();
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "no run after reset", out_valid, 0);
        tick();
        in_valid = 1'b1; in_data = 8'h88; in_last = 1'b1;
        @(negedge clk);
        chk(out_valid && out_data == 8'h88, "R10", "byte passes after reset", out_data, 8'h88);
        tick();
        in_valid = 1'b0; in_last = 1'b0;

        // table walk, each packet with and without output stalls
        for (int pass = 0; pass < 2; pass++) begin
            int c = 0;
            in_b.delete();
            in_l.delete();
            for (int i = 0; i < NV; i++) begin
                in_b.push_back(VEC[i][7:0]);
                in_l.push_back(VEC[i][8]);
                if (VEC[i][8]) begin
                    run_stream(case_req(c), pass == 1);
                    in_b.delete();
                    in_l.delete();
                    c++;
                end
            end
        end

        // R8: largest count
        in_b.delete(); in_l.delete();
        in_b.push_back(8'h77); in_l.push_back(1'b0);
        in_b.push_back(8'h77); in_l.push_back(1'b0);
        in_b.push_back(8'hFF); in_l.push_back(1'b1);
        run_stream("R8", 1'b1);

        finish_run();
    end

endmodule